// File: doc/BRIEF.md
# Shared Mailbox with Ownership Handoff

This block is a small mailbox that two agents share: a requester and a responder. It holds eight 32-bit words. Each side has its own write port and its own combinational read port. The last word is a protocol header. Its top bit tells which side currently holds the mailbox.

The requester holds the mailbox after reset. It fills the payload words and then writes the header. That header write also sets the owner bit, so control passes to the responder at the same clock edge. The responder reads the request and may rewrite the payload. It then writes its response header, which clears the owner bit whatever value it supplied, and control returns to the requester.

A side that does not hold the mailbox cannot change it. A dropped requester write raises a sticky error flag. While the requester function is held in reset, every requester read returns all ones, which lets software tell "in reset" apart from any real header. The responder's view and the stored contents are not affected by this.

Top module: `mbox_handoff`

## Requirements
- R1: While rst_n is low and after it is released, every word reads 0, owner_is_responder is 0, own_pulse is 0 and req_err is 0, so the requester holds the mailbox.
- R2: While owner_is_responder is 0, a requester write stores req_wdata in word req_addr. The new value is readable through both read ports after the next rising edge.
- R3: A requester write to word 7 (the header) stores bits [30:0] unchanged and stores bit 31 as 1 whatever was written. owner_is_responder is 1 from the next edge.
- R4: own_pulse is high for exactly one cycle, in the cycle after an accepted requester header write. It is low at all other times.
- R5: While owner_is_responder is 1, requester writes change no word. req_err goes to 1 after the next edge and stays 1 until rst_n is asserted.
- R6: While owner_is_responder is 1, a responder write stores rsp_wdata in word rsp_addr. A write to word 7 stores bits [30:0] unchanged and bit 31 as 0, and owner_is_responder returns to 0 from the next edge.
- R7: While owner_is_responder is 0, responder writes change no word and raise no error. This also holds when both sides write in the same cycle.
- R8: While fn_rst is 1, req_rdata is 32'hFFFFFFFF for every address. rsp_rdata and the stored words are not affected and read unchanged after fn_rst falls.
- R9: The header fields pass through unchanged: message type in bits [2:0], version in [5:3], direction in bit 7 (0 request, 1 response), status in [15:8] (0 success, non-zero failure) and the reset-function flag in bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| fn_rst | input | 1 | Requester function is in reset; masks requester reads to all ones |
| req_wr | input | 1 | Requester write strobe |
| req_addr | input | 3 | Requester word index, used for both read and write |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data (combinational) |
| rsp_wr | input | 1 | Responder write strobe |
| rsp_addr | input | 3 | Responder word index, used for both read and write |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data (combinational) |
| owner_is_responder | output | 1 | Mirror of header bit 31 |
| own_pulse | output | 1 | One-cycle strobe when ownership arrives at the responder |
| req_err | output | 1 | Sticky flag: a requester write was dropped |

## Verification
The read ports are combinational. They show the present address in the same cycle, and a write becomes visible only after the rising edge that stores it. The owner mirror, the ownership strobe and the error flag change one edge after the write that causes them. The bench drives every input at the falling edge and lets them settle for 1 ns. It then compares both read ports and all three status outputs against a behavioural model, which advances only on the rising edge from the same inputs. Directed steps cover the handoff in both directions, dropped writes from each side and a function reset with the mailbox in both states. A pseudo-random phase follows that mixes all of these.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W    = 32;
  localparam int OWNER_BIT = 31;
  localparam int RSTF_BIT  = 24;
  localparam int DIR_BIT   = 7;

  // Header view of the last word
  typedef struct packed {
    logic       owner;     // 31: 1 = responder holds the mailbox
    logic [5:0] rsv_hi;    // 30:25
    logic       rst_flag;  // 24
    logic [7:0] rsv_mid;   // 23:16
    logic [7:0] status;    // 15:8
    logic       dir;       // 7
    logic       rsv_lo;    // 6
    logic [2:0] version;   // 5:3
    logic [2:0] kind;      // 2:0
  } hdr_t;

  // Replace the owner bit of a header word
  function automatic logic [WORD_W-1:0] with_owner(input logic [WORD_W-1:0] w,
                                                   input logic v);
    hdr_t h;
    h = hdr_t'(w);
    h.owner = v;
    return WORD_W'(h);
  endfunction

  function automatic logic owner_of(input logic [WORD_W-1:0] w);
    return w[OWNER_BIT];
  endfunction
endpackage

// File: rtl/mbox_own.sv
module mbox_own #(
  parameter int NWORDS = 8,
  localparam int AW = $clog2(NWORDS),
  localparam int LAST = NWORDS - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          owner,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic          rsp_wr,
  output logic          req_acc,
  output logic          rsp_acc,
  output logic          req_drop,
  output logic          own_pulse,
  output logic          req_err
);
  assign req_acc  = req_wr & ~owner;
  assign rsp_acc  = rsp_wr & owner;
  assign req_drop = req_wr & owner;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_err   <= 1'b0;
      own_pulse <= 1'b0;
    end else begin
      req_err   <= req_err | req_drop;
      own_pulse <= req_acc && (req_addr == AW'(LAST));
    end
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int NWORDS = 8,
  localparam int AW = $clog2(NWORDS),
  localparam int LAST = NWORDS - 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_acc,
  input  logic [AW-1:0]                 req_addr,
  input  logic [WORD_W-1:0]             req_wdata,
  input  logic                          rsp_acc,
  input  logic [AW-1:0]                 rsp_addr,
  input  logic [WORD_W-1:0]             rsp_wdata,
  output logic [NWORDS-1:0][WORD_W-1:0] words
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    if (i == LAST) begin : g_hdr
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[i] <= '0;
        else if (req_acc && req_addr == AW'(i))
          words[i] <= with_owner(req_wdata, 1'b1);
        else if (rsp_acc && rsp_addr == AW'(i))
          words[i] <= with_owner(rsp_wdata, 1'b0);
      end
    end else begin : g_pay
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[i] <= '0;
        else if (req_acc && req_addr == AW'(i))
          words[i] <= req_wdata;
        else if (rsp_acc && rsp_addr == AW'(i))
          words[i] <= rsp_wdata;
      end
    end
  end
endmodule

// File: rtl/mbox_handoff.sv
module mbox_handoff
  import mbox_pkg::*;
#(
  parameter int NWORDS = 8,
  localparam int AW = $clog2(NWORDS),
  localparam int LAST = NWORDS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fn_rst,
  input  logic              req_wr,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] req_rdata,
  input  logic              rsp_wr,
  input  logic [AW-1:0]     rsp_addr,
  input  logic [WORD_W-1:0] rsp_wdata,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              owner_is_responder,
  output logic              own_pulse,
  output logic              req_err
);
  logic [NWORDS-1:0][WORD_W-1:0] words;
  logic req_acc, rsp_acc, req_drop;
  logic req_last_acc, rsp_last_acc;

  assign owner_is_responder = owner_of(words[LAST]);
  assign req_last_acc = req_acc && (req_addr == AW'(LAST));
  assign rsp_last_acc = rsp_acc && (rsp_addr == AW'(LAST));

  mbox_own #(.NWORDS(NWORDS)) u_own (
    .clk(clk), .rst_n(rst_n), .owner(owner_is_responder),
    .req_wr(req_wr), .req_addr(req_addr), .rsp_wr(rsp_wr),
    .req_acc(req_acc), .rsp_acc(rsp_acc), .req_drop(req_drop),
    .own_pulse(own_pulse), .req_err(req_err)
  );

  mbox_store #(.NWORDS(NWORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .req_acc(req_acc), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_acc(rsp_acc), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata),
    .words(words)
  );

  always_comb begin
    rsp_rdata = '0;
    if (int'(rsp_addr) < NWORDS) rsp_rdata = words[rsp_addr];
    req_rdata = '0;
    if (fn_rst) req_rdata = '1;
    else if (int'(req_addr) < NWORDS) req_rdata = words[req_addr];
  end
endmodule

// File: rtl/mbox_handoff_chk.sv
module mbox_handoff_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fn_rst,
  input logic        req_acc,
  input logic        rsp_acc,
  input logic        req_drop,
  input logic        req_last_acc,
  input logic        rsp_last_acc,
  input logic        owner_is_responder,
  input logic        own_pulse,
  input logic        req_err,
  input logic [31:0] req_rdata
);
  // R3
  handoff_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_last_acc |=> owner_is_responder);
  // R4
  pulse_on_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_pulse |-> (owner_is_responder && $past(req_last_acc)));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> req_err);
  // R5
  drop_raises_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_drop |=> req_err);
  // R6
  handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last_acc |=> !owner_is_responder);
  // R7
  rsp_only_when_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_acc |-> owner_is_responder);
  // R2
  req_only_when_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_acc |-> !owner_is_responder);
  // R8
  fn_rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_rst |-> (req_rdata == 32'hFFFF_FFFF));
endmodule

bind mbox_handoff mbox_handoff_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fn_rst(fn_rst),
  .req_acc(req_acc), .rsp_acc(rsp_acc), .req_drop(req_drop),
  .req_last_acc(req_last_acc), .rsp_last_acc(rsp_last_acc),
  .owner_is_responder(owner_is_responder), .own_pulse(own_pulse),
  .req_err(req_err), .req_rdata(req_rdata)
);

// File: tb/mbox_handoff_bench.sv
module mbox_handoff_bench;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, fn_rst = 1'b0;
  logic req_wr = 1'b0, rsp_wr = 1'b0;
  logic [2:0] req_addr = '0, rsp_addr = '0;
  logic [31:0] req_wdata = '0, rsp_wdata = '0;
  logic [31:0] req_rdata, rsp_rdata;
  logic owner_is_responder, own_pulse, req_err;

  mbox_handoff u_mbox_handoff (
    .clk(clk), .rst_n(rst_n), .fn_rst(fn_rst),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .rsp_wr(rsp_wr), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
    .owner_is_responder(owner_is_responder), .own_pulse(own_pulse), .req_err(req_err)
  );

  // Behavioural reference, advanced on the rising edge
  logic [31:0] m [NW];
  logic m_err, m_pulse;
  int vec = 0, bad = 0;
  bit done = 0;

  always @(posedge clk) begin : model
    logic own;
    logic [31:0] w;
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) m[i] = 32'h0;
      m_err = 1'b0;
      m_pulse = 1'b0;
    end else begin
      own = m[NW-1][31];
      m_pulse = 1'b0;
      if (req_wr) begin
        if (!own) begin
          w = req_wdata;
          if (int'(req_addr) == NW-1) begin w[31] = 1'b1; m_pulse = 1'b1; end
          m[req_addr] = w;
        end else m_err = 1'b1;
      end
      if (rsp_wr && own) begin
        w = rsp_wdata;
        if (int'(rsp_addr) == NW-1) w[31] = 1'b0;
        m[rsp_addr] = w;
      end
    end
  end

  task automatic compare(input string tag);
    logic [31:0] e_req;
    bit miss = 0;
    e_req = fn_rst ? 32'hFFFF_FFFF : m[req_addr];
    vec++;
    if (req_rdata !== e_req) begin
      $display("FAIL %s req_rdata act %h exp %h", tag, req_rdata, e_req); miss = 1;
    end
    if (rsp_rdata !== m[rsp_addr]) begin
      $display("FAIL %s rsp_rdata act %h exp %h", tag, rsp_rdata, m[rsp_addr]); miss = 1;
    end
    if (owner_is_responder !== m[NW-1][31]) begin
      $display("FAIL %s owner act %b exp %b", tag, owner_is_responder, m[NW-1][31]); miss = 1;
    end
    if (own_pulse !== m_pulse) begin
      $display("FAIL %s own_pulse act %b exp %b", tag, own_pulse, m_pulse); miss = 1;
    end
    if (req_err !== m_err) begin
      $display("FAIL %s req_err act %b exp %b", tag, req_err, m_err); miss = 1;
    end
    if (miss) bad++;
  endtask

  // One cycle: drive at the falling edge, check 1 ns later
  task automatic cyc(input string tag, input logic rw, input logic [2:0] ra,
                     input logic [31:0] rd, input logic sw, input logic [2:0] sa,
                     input logic [31:0] sd, input logic fr);
    @(negedge clk);
    req_wr = rw; req_addr = ra; req_wdata = rd;
    rsp_wr = sw; rsp_addr = sa; rsp_wdata = sd; fn_rst = fr;
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag, input logic [2:0] ra, input logic [2:0] sa,
                      input logic fr);
    cyc(tag, 1'b0, ra, 32'h0, 1'b0, sa, 32'h0, fr);
  endtask

  initial begin
    logic [31:0] x;
    x = 32'h1234_5678;
    repeat (3) @(posedge clk);
    // R1: reset state, both during and after reset
    for (int a = 0; a < NW; a++) idle("R1", 3'(a), 3'(NW-1-a), 1'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < NW; a++) idle("R1", 3'(a), 3'(a), 1'b0);
    // R2: payload writes by the requester
    for (int a = 0; a < NW-1; a++)
      cyc("R2", 1'b1, 3'(a), 32'hA5A0_0000 | 32'(a * 32'h111), 1'b0, 3'(a), 32'h0, 1'b0);
    for (int a = 0; a < NW; a++) idle("R2", 3'(a), 3'(NW-1-a), 1'b0);
    // R7: both write in the same cycle while the requester holds it
    cyc("R7", 1'b1, 3'd1, 32'h1111_2222, 1'b1, 3'd1, 32'hDEAD_BEEF, 1'b0);
    cyc("R7", 1'b0, 3'd1, 32'h0, 1'b1, 3'd3, 32'hBAD0_BAD0, 1'b0);
    idle("R7", 3'd3, 3'd1, 1'b0);
    // R3 R9: request header (type 1, reset flag) hands ownership over
    cyc("R3", 1'b1, 3'd7, 32'h0100_0001, 1'b0, 3'd7, 32'h0, 1'b0);
    idle("R4", 3'd7, 3'd7, 1'b0);
    idle("R4", 3'd7, 3'd7, 1'b0);
    // R5: requester writes while the responder holds the mailbox
    cyc("R5", 1'b1, 3'd2, 32'hFEED_0002, 1'b0, 3'd2, 32'h0, 1'b0);
    idle("R5", 3'd2, 3'd2, 1'b0);
    cyc("R5", 1'b1, 3'd7, 32'h0000_0000, 1'b0, 3'd7, 32'h0, 1'b0);
    idle("R5", 3'd7, 3'd7, 1'b0);
    // R8: function reset while the responder holds the mailbox
    for (int a = 0; a < NW; a++) idle("R8", 3'(a), 3'(a), 1'b1);
    // R6: responder payload then response header with bit 31 set (ignored)
    cyc("R6", 1'b0, 3'd0, 32'h0, 1'b1, 3'd0, 32'hC0DE_0000, 1'b0);
    cyc("R6", 1'b0, 3'd7, 32'h0, 1'b1, 3'd7, 32'h8000_0081, 1'b0);
    idle("R9", 3'd7, 3'd0, 1'b0);
    idle("R6", 3'd0, 3'd7, 1'b0);
    // R8: function reset while the requester holds the mailbox
    for (int a = 0; a < NW; a++) idle("R8", 3'(a), 3'(a), 1'b1);
    for (int a = 0; a < NW; a++) idle("R8", 3'(a), 3'(a), 1'b0);
    // R4: second handoff with bit 31 already set, then a failure response
    cyc("R4", 1'b1, 3'd7, 32'h8000_0011, 1'b0, 3'd7, 32'h0, 1'b0);
    idle("R4", 3'd7, 3'd7, 1'b0);
    cyc("R9", 1'b0, 3'd7, 32'h0, 1'b1, 3'd7, 32'h0000_0591, 1'b0);
    idle("R9", 3'd7, 3'd7, 1'b0);
    // Mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      x = x * 32'd1103515245 + 32'd12345;
      cyc("R2", x[3] & x[4], x[7:5], {x[15:0], x[31:16]},
          x[9] & x[10], x[13:11], {x[31:16] ^ 16'h5A5A, x[15:0]}, (x[20:18] == 3'd0));
    end
    // R1: reset again mid-traffic
    @(negedge clk); rst_n = 1'b0;
    idle("R1", 3'd7, 3'd0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < NW; a++) idle("R1", 3'(a), 3'(a), 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule